// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block holds the routing state of an I/O interrupt controller behind a two-location register window. Software writes an index into a select register, then reads or writes the chosen internal register through a 32-bit data window. Behind the window there is a 4-bit identifier, a read-only version word, an arbitration word that reads as zero, and a routing table with one 64-bit entry per interrupt pin. Each entry is reached as two 32-bit halves at an even/odd pair of indices. A write to one half leaves the other half unchanged.

The whole table is presented in parallel to a separate dispatch engine. Every accepted write to a table half raises a one-cycle update strobe that carries the entry number, so the engine knows to re-evaluate its pins. The pending-acknowledge flag (bit 14 of each entry) belongs to the engine. The engine sets and clears it through per-pin request lines, and software cannot change it.

Register requests use a valid/ready handshake. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. A read is answered by `rsp_valid` one cycle after acceptance. The response holds with stable data until `rsp_ready` is seen high. While an answered response is held back, `req_ready` is low. Writes produce no response.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, the select register and the identifier are zero, every table entry equals 0x0000_0000_0001_0000 (only the mask bit 16 set), and `rsp_valid` and `tbl_upd_valid` are low.
- R2: Only address bits 7:0 are decoded. Offset 0x00 is the 8-bit select register, which reads back the last value written (data bits 7:0). Offset 0x10 is the data window. Any other offset reads as zero and ignores writes.
- R3: Window index 0x00 is the identifier. A write keeps data bits 27:24. A read returns them in bits 27:24 with all other bits zero.
- R4: Window index 0x01 reads 0x11 in bits 7:0 and the pin count minus one in bits 23:16, with other bits zero (0x0017_0011 for 24 pins). Writes to it change nothing.
- R5: Window index 0x02 reads as zero and ignores writes.
- R6: Window indices from 0x10 upward select entry (index − 0x10) >> 1. An even index reaches entry bits 31:0 and an odd index reaches bits 63:32. Written values appear on `tbl_entries` and read back through the window.
- R7: A write to one half of an entry leaves the other half unchanged.
- R8: A window index outside 0x00–0x02 and outside the table (0x03–0x0F, and 0x40 upward for 24 pins) reads as zero and ignores writes.
- R9: Each accepted window write to a table half pulses `tbl_upd_valid` for exactly one cycle, in the cycle after acceptance, with `tbl_upd_idx` set to the entry number. No other write pulses it.
- R10: Entry bit 14 ignores software writes. `rirr_set[n]` sets it and `rirr_clr[n]` clears it one cycle later. When both are high, set wins.
- R11: A read is answered one cycle after acceptance. The response holds with stable data until `rsp_ready`, and `req_ready` is low while a response is held back. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte offset; only bits 7:0 decoded |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Requester takes the read data |
| rsp_rdata | output | 32 | Read data |
| tbl_entries | output | NUM_PINS×64 | All routing entries, entry n at index n |
| tbl_upd_valid | output | 1 | One-cycle strobe after a table write |
| tbl_upd_idx | output | $clog2(NUM_PINS) | Entry touched by that write |
| rirr_set | input | NUM_PINS | Per-pin request to set entry bit 14 |
| rirr_clr | input | NUM_PINS | Per-pin request to clear entry bit 14 |

## Verification
A wrong select value or decode error shows on the next window read as data from the wrong register or half. That read is answered one cycle after it is accepted. It also shows on `tbl_entries` in the cycle after a misdirected write, as a changed neighbour entry or an untouched target. A lost half-word merge shows at once on the parallel table output as a cleared opposite half. A fault in engine ownership of bit 14 shows one cycle after the set or clear request, or after a software write that should have left the bit alone. Handshake faults show as a response that changes or disappears while back-pressured.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Offsets within the decoded low address byte
  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;

  // Window indices
  localparam logic [7:0] WIX_IDENT  = 8'h00;
  localparam logic [7:0] WIX_VERSN  = 8'h01;
  localparam logic [7:0] WIX_ARBIT  = 8'h02;
  localparam logic [7:0] WIX_TABLE  = 8'h10;

  localparam logic [7:0] VERSION_CODE = 8'h11;

  // Routing entry fields that the logic depends on
  localparam int PEND_ACK_BIT = 14;
  localparam int MASK_BIT     = 16;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SELECT,
    TGT_IDENT,
    TGT_VERSN,
    TGT_ARBIT,
    TGT_TABLE
  } target_e;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic [7:0]       offset,
  input  logic [7:0]       sel_q,
  output target_e          target,
  output logic [IDX_W-1:0] ent_idx,
  output logic             ent_hi
);

  logic [7:0] rel;
  logic [6:0] ent_full;
  logic       tbl_hit;

  always_comb begin
    rel      = sel_q - WIX_TABLE;
    ent_full = rel[7:1];
    ent_hi   = rel[0];
    ent_idx  = ent_full[IDX_W-1:0];
    tbl_hit  = (sel_q >= WIX_TABLE) && (int'(ent_full) < NUM_PINS);
  end

  always_comb begin
    target = TGT_NONE;
    if (offset == OFS_SELECT) begin
      target = TGT_SELECT;
    end else if (offset == OFS_WINDOW) begin
      case (sel_q)
        WIX_IDENT: target = TGT_IDENT;
        WIX_VERSN: target = TGT_VERSN;
        WIX_ARBIT: target = TGT_ARBIT;
        default:   target = tbl_hit ? TGT_TABLE : TGT_NONE;
      endcase
    end
  end

endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        ack_set,
  input  logic        ack_clr,
  output logic [63:0] entry_q
);

  logic [63:0] entry_d;

  always_comb begin
    entry_d = entry_q;
    if (wr_lo) begin
      entry_d[31:0] = wdata;
    end
    if (wr_hi) begin
      entry_d[63:32] = wdata;
    end
    // Pending-acknowledge flag is owned by the dispatch engine only
    if (ack_set) begin
      entry_d[PEND_ACK_BIT] = 1'b1;
    end else if (ack_clr) begin
      entry_d[PEND_ACK_BIT] = 1'b0;
    end else begin
      entry_d[PEND_ACK_BIT] = entry_q[PEND_ACK_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_q <= ENTRY_RST;
    end else begin
      entry_q <= entry_d;
    end
  end

endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  target_e     target,
  input  logic        ent_hi,
  input  logic [7:0]  sel_q,
  input  logic [3:0]  ident_q,
  input  logic [63:0] ent_rd,
  output logic [31:0] rdata
);

  localparam logic [7:0] LAST_PIN = 8'(NUM_PINS - 1);

  always_comb begin
    case (target)
      TGT_SELECT: rdata = {24'h0, sel_q};
      TGT_IDENT:  rdata = {4'h0, ident_q, 24'h0};
      TGT_VERSN:  rdata = {8'h00, LAST_PIN, 8'h00, VERSION_CODE};
      TGT_TABLE:  rdata = ent_hi ? ent_rd[63:32] : ent_rd[31:0];
      default:    rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 12,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [31:0]               req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [31:0]               rsp_rdata,
  output logic [NUM_PINS-1:0][63:0] tbl_entries,
  output logic                      tbl_upd_valid,
  output logic [IDX_W-1:0]          tbl_upd_idx,
  input  logic [NUM_PINS-1:0]       rirr_set,
  input  logic [NUM_PINS-1:0]       rirr_clr
);

  logic [7:0]       sel_q;
  logic [3:0]       ident_q;
  target_e          target;
  logic [IDX_W-1:0] ent_idx;
  logic             ent_hi;
  logic             win_tbl;
  logic             acc, acc_wr, acc_rd, wr_tbl;
  logic [63:0]      ent_rd;
  logic [31:0]      rd_word;
  logic             rsp_valid_q;
  logic [31:0]      rsp_rdata_q;
  logic             unused_addr_hi;

  assign unused_addr_hi = ^req_addr[ADDR_W-1:8];

  // Handshake: a held response blocks new requests
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign acc_wr    = acc && req_write;
  assign acc_rd    = acc && !req_write;

  irq_route_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .offset  (req_addr[7:0]),
    .sel_q   (sel_q),
    .target  (target),
    .ent_idx (ent_idx),
    .ent_hi  (ent_hi)
  );

  assign win_tbl = (target == TGT_TABLE);
  assign wr_tbl  = acc_wr && win_tbl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 8'h00;
      ident_q <= 4'h0;
    end else begin
      if (acc_wr && target == TGT_SELECT) begin
        sel_q <= req_wdata[7:0];
      end
      if (acc_wr && target == TGT_IDENT) begin
        ident_q <= req_wdata[27:24];
      end
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    logic hit;
    assign hit = wr_tbl && (ent_idx == IDX_W'(g));
    irq_route_entry u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (hit && !ent_hi),
      .wr_hi   (hit && ent_hi),
      .wdata   (req_wdata),
      .ack_set (rirr_set[g]),
      .ack_clr (rirr_clr[g]),
      .entry_q (tbl_entries[g])
    );
  end

  assign ent_rd = win_tbl ? tbl_entries[ent_idx] : 64'h0;

  irq_route_rdmux #(.NUM_PINS(NUM_PINS)) u_rd (
    .target  (target),
    .ent_hi  (ent_hi),
    .sel_q   (sel_q),
    .ident_q (ident_q),
    .ent_rd  (ent_rd),
    .rdata   (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= 32'h0;
    end else if (acc_rd) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_upd_valid <= 1'b0;
      tbl_upd_idx   <= '0;
    end else begin
      tbl_upd_valid <= wr_tbl;
      if (wr_tbl) begin
        tbl_upd_idx <= ent_idx;
      end
    end
  end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      req_write,
  input logic                      rsp_valid,
  input logic                      rsp_ready,
  input logic [31:0]               rsp_rdata,
  input logic [NUM_PINS-1:0][63:0] tbl_entries,
  input logic                      tbl_upd_valid,
  input logic [NUM_PINS-1:0]       rirr_set,
  input logic [NUM_PINS-1:0]       rirr_clr,
  input logic [7:0]                sel_q,
  input logic                      win_tbl
);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R11
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R11
  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write)); // R11
  AST_UPD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && win_tbl |=> tbl_upd_valid); // R9
  AST_UPD_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_upd_valid |-> $past(req_valid && req_ready && req_write && win_tbl)); // R9
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> $stable(sel_q)); // R2

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    AST_ACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rirr_set[g] |=> tbl_entries[g][14]); // R10
    AST_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      rirr_clr[g] && !rirr_set[g] |=> !tbl_entries[g][14]); // R10
    AST_ACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !rirr_set[g] && !rirr_clr[g] |=> $stable(tbl_entries[g][14])); // R10
  end

endmodule

bind irq_route_regs irq_route_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_rdata     (rsp_rdata),
  .tbl_entries   (tbl_entries),
  .tbl_upd_valid (tbl_upd_valid),
  .rirr_set      (rirr_set),
  .rirr_clr      (rirr_clr),
  .sel_q         (sel_q),
  .win_tbl       (win_tbl)
);

// File: tb/irq_route_regs_tb.sv
`timescale 1ns/1ps
module irq_route_regs_tb;

  localparam int NUM_PINS = 24;
  localparam int ADDR_W   = 12;
  localparam int IDX_W    = $clog2(NUM_PINS);

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic                      req_valid = 1'b0;
  logic                      req_ready;
  logic                      req_write = 1'b0;
  logic [ADDR_W-1:0]         req_addr = '0;
  logic [31:0]               req_wdata = '0;
  logic                      rsp_valid;
  logic                      rsp_ready = 1'b1;
  logic [31:0]               rsp_rdata;
  logic [NUM_PINS-1:0][63:0] tbl_entries;
  logic                      tbl_upd_valid;
  logic [IDX_W-1:0]          tbl_upd_idx;
  logic [NUM_PINS-1:0]       rirr_set = '0;
  logic [NUM_PINS-1:0]       rirr_clr = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  irq_route_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dut (.*);

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;   // write data, or expected read data
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0000_0000, 8'd1},  // R1 select resets to 0
    '{1'b1, 12'h000, 32'h0000_0000, 8'd1},
    '{1'b0, 12'h010, 32'h0000_0000, 8'd1},  // R1 identifier resets to 0
    '{1'b1, 12'h010, 32'hFFFF_FFFF, 8'd3},
    '{1'b0, 12'h010, 32'h0F00_0000, 8'd3},  // R3 only bits 27:24 kept
    '{1'b1, 12'h000, 32'h0000_0001, 8'd4},
    '{1'b0, 12'h010, 32'h0017_0011, 8'd4},  // R4 version word
    '{1'b1, 12'h010, 32'h1234_5678, 8'd4},
    '{1'b0, 12'h010, 32'h0017_0011, 8'd4},  // R4 write ignored
    '{1'b0, 12'h000, 32'h0000_0001, 8'd2},  // R2 select readback
    '{1'b1, 12'h000, 32'h0000_0002, 8'd5},
    '{1'b1, 12'h010, 32'hFFFF_FFFF, 8'd5},
    '{1'b0, 12'h010, 32'h0000_0000, 8'd5},  // R5 arbitration zero
    '{1'b1, 12'h000, 32'h0000_0010, 8'd1},
    '{1'b0, 12'h010, 32'h0001_0000, 8'd1},  // R1 entry 0 low after reset
    '{1'b1, 12'h010, 32'h0000_A5F1, 8'd6},
    '{1'b0, 12'h010, 32'h0000_A5F1, 8'd6},  // R6 even index = low half
    '{1'b1, 12'h000, 32'h0000_0011, 8'd6},
    '{1'b1, 12'h010, 32'hAB00_0000, 8'd6},
    '{1'b0, 12'h010, 32'hAB00_0000, 8'd6},  // R6 odd index = high half
    '{1'b1, 12'h000, 32'h0000_0010, 8'd7},
    '{1'b0, 12'h010, 32'h0000_A5F1, 8'd7},  // R7 low half kept
    '{1'b1, 12'h000, 32'h0000_003F, 8'd6},
    '{1'b1, 12'h010, 32'h5A00_0000, 8'd6},
    '{1'b0, 12'h010, 32'h5A00_0000, 8'd6},  // R6 last entry high half
    '{1'b1, 12'h000, 32'h0000_003E, 8'd7},
    '{1'b0, 12'h010, 32'h0001_0000, 8'd7},  // R7 last entry low kept
    '{1'b1, 12'h000, 32'h0000_0040, 8'd8},
    '{1'b1, 12'h010, 32'hFFFF_FFFF, 8'd8},
    '{1'b0, 12'h010, 32'h0000_0000, 8'd8},  // R8 past the table
    '{1'b1, 12'h000, 32'h0000_0005, 8'd8},
    '{1'b0, 12'h010, 32'h0000_0000, 8'd8},  // R8 gap below the table
    '{1'b0, 12'h020, 32'h0000_0000, 8'd2},  // R2 unknown offset reads 0
    '{1'b1, 12'h004, 32'h0000_0077, 8'd2},
    '{1'b0, 12'h000, 32'h0000_0005, 8'd2},  // R2 unknown offset write ignored
    '{1'b1, 12'h100, 32'h0000_01FF, 8'd2},
    '{1'b0, 12'h000, 32'h0000_00FF, 8'd2}   // R2 alias via low byte, 8-bit select
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    check("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
    check("R1 tbl_upd_valid", {63'h0, tbl_upd_valid}, 64'h0);
    for (int p = 0; p < NUM_PINS; p++) begin
      check("R1 entry reset", tbl_entries[p], 64'h0000_0000_0001_0000);
    end

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        bus_write(VECS[i].addr, VECS[i].data);
      end else begin
        bus_read(VECS[i].addr, rd);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), {32'h0, rd}, {32'h0, VECS[i].data});
      end
    end

    // R6 / R7 parallel table view
    check("R6 entry0 on port", tbl_entries[0], 64'hAB00_0000_0000_A5F1);
    check("R7 entry23 on port", tbl_entries[23], 64'h5A00_0000_0001_0000);
    check("R8 entry1 untouched", tbl_entries[1], 64'h0000_0000_0001_0000);

    // R9 update strobe
    bus_write(12'h000, 32'h2D);  // entry 14 high half
    check("R9 no strobe on select write", {63'h0, tbl_upd_valid}, 64'h0);
    bus_write(12'h010, 32'h0100_0000);
    check("R9 strobe high", {63'h0, tbl_upd_valid}, 64'h1);
    check("R9 strobe index", {{(64-IDX_W){1'b0}}, tbl_upd_idx}, 64'd14);
    @(negedge clk);
    check("R9 strobe one cycle", {63'h0, tbl_upd_valid}, 64'h0);
    bus_write(12'h000, 32'h00);
    bus_write(12'h010, 32'h0300_0000);
    check("R9 no strobe on identifier write", {63'h0, tbl_upd_valid}, 64'h0);

    // R10 pending-acknowledge ownership, entry 5 (index 0x1A)
    @(negedge clk);
    rirr_set[5] = 1'b1;
    @(negedge clk);
    rirr_set[5] = 1'b0;
    check("R10 set", {63'h0, tbl_entries[5][14]}, 64'h1);
    bus_write(12'h000, 32'h1A);
    bus_read(12'h010, rd);
    check("R10 readback set", {32'h0, rd}, 64'h0001_4000);
    bus_write(12'h010, 32'h0000_0000);
    bus_read(12'h010, rd);
    check("R10 software clear ignored", {32'h0, rd}, 64'h0000_4000);
    rirr_set[5] = 1'b1; rirr_clr[5] = 1'b1;
    @(negedge clk);
    rirr_set[5] = 1'b0; rirr_clr[5] = 1'b0;
    check("R10 set wins", {63'h0, tbl_entries[5][14]}, 64'h1);
    rirr_clr[5] = 1'b1;
    @(negedge clk);
    rirr_clr[5] = 1'b0;
    check("R10 clear", {63'h0, tbl_entries[5][14]}, 64'h0);
    bus_write(12'h010, 32'h0000_4000);
    check("R10 software set ignored", tbl_entries[5], 64'h0);

    // R11 handshake and back-pressure
    bus_write(12'h000, 32'h01);
    check("R11 no response to write", {63'h0, rsp_valid}, 64'h0);
    rsp_ready = 1'b0;
    bus_read(12'h010, rd);
    held = rd;
    check("R11 response data", {32'h0, held}, 64'h0017_0011);
    @(negedge clk);
    @(negedge clk);
    check("R11 response held", {63'h0, rsp_valid}, 64'h1);
    check("R11 data stable", {32'h0, rsp_rdata}, {32'h0, held});
    check("R11 ready low while held", {63'h0, req_ready}, 64'h0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R11 response taken", {63'h0, rsp_valid}, 64'h0);

    finish_run();
  end

endmodule